// File: doc/BRIEF.md
# Multiplier Group with Operand Delay Chain and Output Feedback

This block is the multiply core of a small filter engine. It holds four lanes, each a registered pair of operands feeding an 18x18 multiplier whose 36-bit product is registered again. How the operand registers load is chosen each cycle. They can load in parallel from their own external inputs. The A registers can instead form a tap-delay line, each lane taking the A value held by the lane before it, as a FIR kernel needs. The first lane's B register can also take the upper half of its own registered product, which serves a recursive filter.

Operands arrive narrower than the native 18 bits (16 by default) and are widened as they enter their registers. Two sign controls, one for all A operands and one for all B operands, choose two's complement or unsigned reading. A single flag reports whether the products are to be read as signed. All registers share one clock, one enable and one synchronous clear.

Top module: `fir_mult_group`

## Requirements
- R1: After asynchronous reset (rst_ni low) every product lane and prod_signed_o read 0.
- R2: With en_i high, operands presented before clock edge k appear as the product of each lane on prod_o (lane i at bits [36*i+35:36*i]) after edge k+1.
- R3: sign_a_i=1 reads the A operands as two's complement and sign_a_i=0 reads them as unsigned; sign_b_i does the same for the B operands.
- R4: prod_signed_o is 1 when at least one of the two sign controls was 1 for the operands that produced the current products, and 0 only when both were 0.
- R5: Each OPD_W-bit operand is widened to 18 bits by copying its top bit when its sign control is 1, and by adding zeros when it is 0.
- R6: With shift_a_i=1, the A register of lane i (i>=1) loads the A register value of lane i-1 and the external A inputs of lanes 1..3 are ignored; lane 0's A register always loads from its external input.
- R7: The B registers of lanes 1..3 always load from their external inputs, whatever loop_b_i is.
- R8: With loop_b_i=1, lane 0's B register loads bits [35:18] of lane 0's registered product, and lane 0's external B input is ignored.
- R9: shift_a_i and loop_b_i are sampled at every edge, so a mode change acts on the very next operand load.
- R10: With en_i low and clr_i low, all registers, and so prod_o and prod_signed_o, hold their values.
- R11: clr_i high at an edge clears all operand and product registers, whatever en_i is; the outputs read 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Load enable for all registers |
| clr_i | input | 1 | Synchronous clear of all registers |
| a_i | input | 4*OPD_W | A operands, lane i at [OPD_W*i +: OPD_W] |
| b_i | input | 4*OPD_W | B operands, lane i at [OPD_W*i +: OPD_W] |
| sign_a_i | input | 1 | 1: A operands are two's complement |
| sign_b_i | input | 1 | 1: B operands are two's complement |
| shift_a_i | input | 1 | 1: A registers form a delay chain |
| loop_b_i | input | 1 | 1: lane 0 B register takes product feedback |
| prod_o | output | 4*36 | Registered products, lane i at [36*i +: 36] |
| prod_signed_o | output | 1 | 1: products are two's complement |

## Verification
Operands and modes are sampled at one rising edge and the products and signed flag change at the next, so every result is due two edges after its stimulus is driven. The bench drives on falling edges and reads outputs at the falling edge after the second rising edge. Delay-chain and feedback sequences are checked edge by edge, each expected value worked out from which register held what one cycle earlier. Hold and clear checks read the outputs one edge after the condition is applied.

// File: rtl/fir_mult_pkg.sv
package fir_mult_pkg;
  localparam int NAT_W  = 18;
  localparam int PROD_W = 2 * NAT_W;

  // Interpret each operand per its sign bit, multiply in 19-bit signed space.
  function automatic logic [PROD_W-1:0] mul_nat(input logic [NAT_W-1:0] a,
                                                input logic [NAT_W-1:0] b,
                                                input logic sa,
                                                input logic sb);
    logic signed [NAT_W:0]      ea;
    logic signed [NAT_W:0]      eb;
    logic signed [2*NAT_W+1:0]  p;
    ea = {sa & a[NAT_W-1], a};
    eb = {sb & b[NAT_W-1], b};
    p  = ea * eb;
    return p[PROD_W-1:0];
  endfunction
endpackage

// File: rtl/fir_operand_regs.sv
module fir_operand_regs
  import fir_mult_pkg::*;
#(
  parameter int N_LANE = 4,
  parameter int OPD_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic                           clr_i,
  input  logic [N_LANE-1:0][OPD_W-1:0]   a_i,
  input  logic [N_LANE-1:0][OPD_W-1:0]   b_i,
  input  logic                           sign_a_i,
  input  logic                           sign_b_i,
  input  logic                           shift_a_i,
  input  logic                           loop_b_i,
  input  logic [NAT_W-1:0]               fb_i,
  output logic [N_LANE-1:0][NAT_W-1:0]   a_q_o,
  output logic [N_LANE-1:0][NAT_W-1:0]   b_q_o,
  output logic                           sa_q_o,
  output logic                           sb_q_o
);
  localparam int PAD_W = NAT_W - OPD_W;

  logic [N_LANE-1:0][NAT_W-1:0] a_pad, b_pad, a_nxt, b_nxt;

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    if (PAD_W > 0) begin : g_pad
      assign a_pad[i] = {{PAD_W{sign_a_i & a_i[i][OPD_W-1]}}, a_i[i]};
      assign b_pad[i] = {{PAD_W{sign_b_i & b_i[i][OPD_W-1]}}, b_i[i]};
    end else begin : g_nopad
      assign a_pad[i] = a_i[i];
      assign b_pad[i] = b_i[i];
    end

    if (i == 0) begin : g_first
      assign a_nxt[i] = a_pad[i];
      assign b_nxt[i] = loop_b_i ? fb_i : b_pad[i];
    end else begin : g_rest
      assign a_nxt[i] = shift_a_i ? a_q_o[i-1] : a_pad[i];
      assign b_nxt[i] = b_pad[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q_o[i] <= '0;
        b_q_o[i] <= '0;
      end else if (clr_i) begin
        a_q_o[i] <= '0;
        b_q_o[i] <= '0;
      end else if (en_i) begin
        a_q_o[i] <= a_nxt[i];
        b_q_o[i] <= b_nxt[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_q_o <= 1'b0;
      sb_q_o <= 1'b0;
    end else if (clr_i) begin
      sa_q_o <= 1'b0;
      sb_q_o <= 1'b0;
    end else if (en_i) begin
      sa_q_o <= sign_a_i;
      sb_q_o <= sign_b_i;
    end
  end
endmodule

// File: rtl/fir_mult_lane.sv
module fir_mult_lane
  import fir_mult_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [NAT_W-1:0]  a_i,
  input  logic [NAT_W-1:0]  b_i,
  input  logic              sa_i,
  input  logic              sb_i,
  output logic [PROD_W-1:0] prod_q_o
);
  logic [PROD_W-1:0] prod_d;

  assign prod_d = mul_nat(a_i, b_i, sa_i, sb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prod_q_o <= '0;
    else if (clr_i)  prod_q_o <= '0;
    else if (en_i)   prod_q_o <= prod_d;
  end
endmodule

// File: rtl/fir_mult_group.sv
module fir_mult_group
  import fir_mult_pkg::*;
#(
  parameter int N_LANE = 4,
  parameter int OPD_W  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       clr_i,
  input  logic [N_LANE*OPD_W-1:0]    a_i,
  input  logic [N_LANE*OPD_W-1:0]    b_i,
  input  logic                       sign_a_i,
  input  logic                       sign_b_i,
  input  logic                       shift_a_i,
  input  logic                       loop_b_i,
  output logic [N_LANE*PROD_W-1:0]   prod_o,
  output logic                       prod_signed_o
);
  logic [N_LANE-1:0][OPD_W-1:0]  a_v, b_v;
  logic [N_LANE-1:0][NAT_W-1:0]  a_q, b_q;
  logic [N_LANE-1:0][PROD_W-1:0] prod_q;
  logic                          sa_q, sb_q;
  logic [NAT_W-1:0]              fb;

  for (genvar i = 0; i < N_LANE; i++) begin : g_map
    assign a_v[i] = a_i[i*OPD_W +: OPD_W];
    assign b_v[i] = b_i[i*OPD_W +: OPD_W];
    assign prod_o[i*PROD_W +: PROD_W] = prod_q[i];
  end

  // Upper half of lane 0's registered product feeds its B register.
  assign fb = prod_q[0][PROD_W-1:NAT_W];

  fir_operand_regs #(.N_LANE(N_LANE), .OPD_W(OPD_W)) u_opd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .clr_i     (clr_i),
    .a_i       (a_v),
    .b_i       (b_v),
    .sign_a_i  (sign_a_i),
    .sign_b_i  (sign_b_i),
    .shift_a_i (shift_a_i),
    .loop_b_i  (loop_b_i),
    .fb_i      (fb),
    .a_q_o     (a_q),
    .b_q_o     (b_q),
    .sa_q_o    (sa_q),
    .sb_q_o    (sb_q)
  );

  for (genvar i = 0; i < N_LANE; i++) begin : g_mul
    fir_mult_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .clr_i    (clr_i),
      .a_i      (a_q[i]),
      .b_i      (b_q[i]),
      .sa_i     (sa_q),
      .sb_i     (sb_q),
      .prod_q_o (prod_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prod_signed_o <= 1'b0;
    else if (clr_i)  prod_signed_o <= 1'b0;
    else if (en_i)   prod_signed_o <= sa_q | sb_q;
  end
endmodule

// File: rtl/fir_mult_group_chk.sv
module fir_mult_group_chk
  import fir_mult_pkg::*;
#(
  parameter int N_LANE = 4,
  parameter int OPD_W  = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       en_i,
  input logic                       clr_i,
  input logic                       shift_a_i,
  input logic                       loop_b_i,
  input logic [N_LANE*PROD_W-1:0]   prod_o,
  input logic                       prod_signed_o,
  input logic [N_LANE-1:0][NAT_W-1:0] a_q,
  input logic [N_LANE-1:0][NAT_W-1:0] b_q,
  input logic                       sa_q,
  input logic                       sb_q
);
  logic ld;
  assign ld = en_i && !clr_i;

  assert_product_lane0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> prod_o[PROD_W-1:0] == $past(mul_nat(a_q[0], b_q[0], sa_q, sb_q)));

  assert_signed_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> prod_signed_o == $past(sa_q | sb_q));

  for (genvar i = 1; i < N_LANE; i++) begin : g_chain
    assert_delay_chain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld && shift_a_i) |=> a_q[i] == $past(a_q[i-1]));
  end

  assert_feedback_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld && loop_b_i) |=> b_q[0] == $past(prod_o[PROD_W-1:NAT_W]));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(prod_o) && $stable(prod_signed_o) && $stable(a_q) && $stable(b_q)));

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (prod_o == '0 && !prod_signed_o && a_q == '0 && b_q == '0));
endmodule

bind fir_mult_group fir_mult_group_chk #(.N_LANE(N_LANE), .OPD_W(OPD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .clr_i         (clr_i),
  .shift_a_i     (shift_a_i),
  .loop_b_i      (loop_b_i),
  .prod_o        (prod_o),
  .prod_signed_o (prod_signed_o),
  .a_q           (a_q),
  .b_q           (b_q),
  .sa_q          (sa_q),
  .sb_q          (sb_q)
);

// File: tb/tb_fir_mult_group.sv
`timescale 1ns/1ps
module tb_fir_mult_group;
  localparam int N   = 4;
  localparam int W   = 16;
  localparam int PW  = 36;

  typedef struct packed {
    logic [W-1:0]  a;
    logic [W-1:0]  b;
    logic          sa;
    logic          sb;
    logic [PW-1:0] exp;
    logic          exp_s;
  } vec_t;

  // Parallel-mode vectors, same operands on every lane (R2, R3, R4, R5).
  localparam vec_t VECS [7] = '{
    '{16'h0003, 16'h0005, 1'b0, 1'b0, 36'h00000000F, 1'b0},
    '{16'hFFFF, 16'h0002, 1'b1, 1'b0, 36'hFFFFFFFFE, 1'b1},
    '{16'hFFFF, 16'h0002, 1'b0, 1'b0, 36'h00001FFFE, 1'b0},
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 36'h000000001, 1'b1},
    '{16'h8000, 16'h8000, 1'b1, 1'b1, 36'h040000000, 1'b1},
    '{16'h8000, 16'hFFFF, 1'b0, 1'b1, 36'hFFFFF8000, 1'b1},
    '{16'h0064, 16'hFFFF, 1'b1, 1'b0, 36'h00063FF9C, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0, clr = 1'b0;
  logic [N*W-1:0]  a = '0, b = '0;
  logic            sa = 1'b0, sb = 1'b0, shf = 1'b0, lpb = 1'b0;
  logic [N*PW-1:0] prod;
  logic            psig;
  int              n_chk = 0, n_bad = 0;
  bit              done = 1'b0;

  always #5 clk = ~clk;

  fir_mult_group #(.N_LANE(N), .OPD_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr),
    .a_i(a), .b_i(b), .sign_a_i(sa), .sign_b_i(sb),
    .shift_a_i(shf), .loop_b_i(lpb),
    .prod_o(prod), .prod_signed_o(psig)
  );

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] lane(input int i);
    return prod[i*PW +: PW];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) chk("R1 prod", lane(i), '0);
    chk("R1 signed", {35'd0, psig}, '0);
    rst_n = 1'b1;
    step();

    // Vector table: R2 latency, R3 sign, R4 flag, R5 padding
    en = 1'b1;
    for (int v = 0; v < 7; v++) begin
      a = {N{VECS[v].a}}; b = {N{VECS[v].b}};
      sa = VECS[v].sa; sb = VECS[v].sb;
      step();
      a = '0; b = '0;
      step();
      for (int i = 0; i < N; i++) chk("R2/R3/R5 prod", lane(i), VECS[v].exp);
      chk("R4 signed", {35'd0, psig}, {35'd0, VECS[v].exp_s});
    end

    // R10: hold with en low
    a = {N{16'h0003}}; b = {N{16'h0007}}; sa = 1'b0; sb = 1'b0;
    step(); step();
    en = 1'b0; a = {N{16'h0100}}; b = {N{16'h0100}}; sa = 1'b1;
    step(); step(); step();
    for (int i = 0; i < N; i++) chk("R10 hold", lane(i), 36'd21);
    chk("R10 signed hold", {35'd0, psig}, '0);

    // R11: clear wins over en low
    sa = 1'b0;
    clr = 1'b1;
    step();
    clr = 1'b0;
    for (int i = 0; i < N; i++) chk("R11 clear", lane(i), '0);
    en = 1'b1;

    // R6/R9: delay chain
    a = {16'd40, 16'd30, 16'd20, 16'd10}; b = {N{16'd1}};
    step();
    shf = 1'b1;
    a = {16'd999, 16'd999, 16'd999, 16'd7};
    step();
    chk("R9 prod0 pre-shift", lane(0), 36'd10);
    chk("R9 prod3 pre-shift", lane(3), 36'd40);
    step();
    chk("R6 lane0", lane(0), 36'd7);
    chk("R6 lane1", lane(1), 36'd10);
    chk("R6 lane2", lane(2), 36'd20);
    chk("R6 lane3", lane(3), 36'd30);
    shf = 1'b0;
    step(); step();
    chk("R9 lane3 parallel again", lane(3), 36'd999);

    // R8/R7: feedback into lane 0 B
    clr = 1'b1;
    step();
    clr = 1'b0;
    a = {16'd0, 16'd0, 16'd3, 16'h4000}; b = {16'd0, 16'd0, 16'd5, 16'h0010};
    step();
    lpb = 1'b1;
    b = {16'd0, 16'd0, 16'd5, 16'h1234};
    step();
    chk("R8 first product", lane(0), 36'h000040000);
    step();
    chk("R8 fed-back zero", lane(0), 36'd0);
    step();
    chk("R8 fed-back one", lane(0), 36'h000004000);
    chk("R7 lane1 B parallel", lane(1), 36'd15);
    lpb = 1'b0;
    step(); step();
    chk("R8 external B again", lane(0), 36'h0048D0000);

    done = 1'b1;
    summary();
  end
endmodule